// File: doc/BRIEF.md
# Per-Stream Stall Buffer

This block sits in a pipeline that interleaves chunks from several streams on one set of wires. Each chunk carries a control word (kind, end marker, flush marker, stream number, tag) and a data word, and the data word arrives one cycle after its control word. The block is given one stream to look after. When its owner raises `pause_i`, chunks of that stream are held in a FIFO. The matching bit of a per-stream stall vector goes upstream, so that the sources stop sending that stream. Chunks of every other stream, and all setup and memory-transfer chunks, keep flowing with no change.

The upstream sources react to a stall bit late. The delay is the time the stall bit takes to reach the previous stall point, plus the pipeline stages between that point and this block. So the FIFO is sized from two parameters: `STALL_DELAY` and `UP_DEPTH`. Its capacity is their sum plus one. When the stream is released, the held chunks go back onto the wires in the free slots that pass by, oldest first. A flush of the held stream drops everything the FIFO holds for it.

Top module: `stream_hold_buffer`

## Requirements
- R1: The stall vector has one bit per stream. Only the bit indexed by `hold_stream_i` can ever be high. Every other bit stays low.
- R2: The held stream's stall bit is high in the cycle after any cycle in which either of these is true: `pause_i` is high, or the buffer is occupied (a capture is in progress, or the occupancy has reached capacity minus the in-flight allowance) and no flush of that stream is arriving. Otherwise the stall bit is low.
- R3: A chunk of the held stream is captured if `pause_i` is high or the buffer is not empty. Such a chunk is either user data (kind 2'b01) or an end-only marker (kind 2'b00 with end high). Its slot then leaves the block as a free chunk: kind 2'b00, end low, flush low, data zero.
- R4: Chunks of other streams pass through unchanged, even while the held stream is paused. So do setup chunks (kind 2'b10) and memory-transfer chunks (kind 2'b11), whatever their stream field holds.
- R5: When `pause_i` is low, each free input slot (kind 2'b00, end and flush low) carries the oldest buffered chunk, with its original control fields and data.
- R6: A chunk of the held stream that arrives while older chunks are still buffered is queued behind them, even when `pause_i` is low. Chunk order within the stream is kept.
- R7: A flush chunk of the held stream (flush high, kind 2'b00 or 2'b01) empties the buffer at once, including a capture still in progress. The flush chunk itself passes through. If `pause_i` is low, the stall bit is low in the next cycle.
- R8: The capacity is `STALL_DELAY + UP_DEPTH + 1` chunks. All of them are released intact. A capture into a full buffer is discarded, and an assertion flags it.
- R9: During reset every output slot is a free chunk and the stall vector is zero.
- R10: Output control lags input control by one cycle. Output data lags its own output control by one cycle, the same offset as at the input.
- R11: Release never overwrites a slot that is not free. End-only and flush-only chunks of other streams pass through while the buffer drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_stream_i | input | SID_W | Stream this block may hold |
| pause_i | input | 1 | Request to hold the selected stream |
| in_kind | input | 2 | Chunk kind: 00 none, 01 user, 10 setup, 11 memory |
| in_last | input | 1 | End-of-stream marker |
| in_flush | input | 1 | Flush marker |
| in_strm | input | SID_W | Stream number |
| in_tag | input | TAG_W | Chunk tag |
| in_data | input | DATA_W | Data word, one cycle after its control |
| out_kind | output | 2 | Output chunk kind |
| out_last | output | 1 | Output end marker |
| out_flush | output | 1 | Output flush marker |
| out_strm | output | SID_W | Output stream number |
| out_tag | output | TAG_W | Output chunk tag |
| out_data | output | DATA_W | Output data, one cycle after its control |
| stall_o | output | 2**SID_W | Per-stream stall vector |

## Verification
A capture and a release can never share a cycle, because each input slot is either free or carries a chunk. The case that can collide is a flush of the held stream arriving in the same cycle that the data word of a just-captured chunk lands in the FIFO. The bench provokes it by sending a flush right behind held chunks. It then judges the result by the release slots that follow: they must carry nothing, and only the flush chunk may appear at the output. A second overlap is also checked: a new held-stream chunk arrives after `pause_i` has dropped but before the FIFO has drained, and it must leave behind the older chunks.

// File: rtl/shb_pkg.sv
package shb_pkg;

  typedef enum logic [1:0] {
    K_IDLE  = 2'b00,
    K_USER  = 2'b01,
    K_SETUP = 2'b10,
    K_MEM   = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    SRC_PASS = 2'b00,
    SRC_POP  = 2'b01,
    SRC_ZERO = 2'b10
  } src_e;

endpackage

// File: rtl/shb_classify.sv
module shb_classify
  import shb_pkg::*;
#(
  parameter int SID_W = 3
) (
  input  logic [1:0]       kind,
  input  logic             last,
  input  logic             flush,
  input  logic [SID_W-1:0] strm,
  input  logic [SID_W-1:0] sel,
  output logic             is_free,
  output logic             sel_flush,
  output logic             sel_chunk
);

  logic stream_kind;
  logic same_strm;

  // Setup and memory chunks reuse the stream field as an address, so they never match.
  always_comb begin
    stream_kind = (kind == K_USER) || (kind == K_IDLE);
    same_strm   = (strm == sel);
    is_free     = (kind == K_IDLE) && !last && !flush;
    sel_flush   = flush && stream_kind && same_strm;
    sel_chunk   = !flush && same_strm &&
                  ((kind == K_USER) || ((kind == K_IDLE) && last));
  end

endmodule

// File: rtl/shb_fifo.sv
module shb_fifo #(
  parameter int DEPTH  = 6,
  parameter int META_W = 11,
  parameter int DATA_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [META_W-1:0] wr_meta,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [META_W-1:0] rd_meta,
  output logic [DATA_W-1:0] rd_data_q,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              full
);

  logic [META_W-1:0] meta_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;
  logic              wr_ok;
  logic              rd_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty = (count == '0);
    full  = (count == CNT_W'(DEPTH));
    wr_ok = wr_en && !full;
    rd_ok = rd_en && !empty;
    // Control fields are read asynchronously so the output control stays one stage.
    rd_meta = meta_mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      meta_mem[wr_ptr] <= wr_meta;
      data_mem[wr_ptr] <= wr_data;
    end
  end

  // Registered read port for the wide data, suited to block RAM.
  always_ff @(posedge clk) begin
    if (rd_ok) rd_data_q <= data_mem[rd_ptr];
  end

endmodule

// File: rtl/shb_stall_gen.sv
module shb_stall_gen #(
  parameter int SID_W = 3,
  localparam int NUM_STREAMS = 1 << SID_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   want,
  input  logic [SID_W-1:0]       sel,
  output logic [NUM_STREAMS-1:0] stall_o
);

  logic [NUM_STREAMS-1:0] hit;

  for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_hit
    assign hit[i] = (sel == SID_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) stall_o <= '0;
    else     stall_o <= want ? hit : '0;
  end

endmodule

// File: rtl/stream_hold_buffer.sv
module stream_hold_buffer
  import shb_pkg::*;
#(
  parameter int SID_W       = 3,
  parameter int TAG_W       = 4,
  parameter int DATA_W      = 32,
  parameter int STALL_DELAY = 2,
  parameter int UP_DEPTH    = 3,
  localparam int NUM_STREAMS = 1 << SID_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SID_W-1:0]       hold_stream_i,
  input  logic                   pause_i,
  input  logic [1:0]             in_kind,
  input  logic                   in_last,
  input  logic                   in_flush,
  input  logic [SID_W-1:0]       in_strm,
  input  logic [TAG_W-1:0]       in_tag,
  input  logic [DATA_W-1:0]      in_data,
  output logic [1:0]             out_kind,
  output logic                   out_last,
  output logic                   out_flush,
  output logic [SID_W-1:0]       out_strm,
  output logic [TAG_W-1:0]       out_tag,
  output logic [DATA_W-1:0]      out_data,
  output logic [NUM_STREAMS-1:0] stall_o
);

  localparam int IN_FLIGHT = STALL_DELAY + UP_DEPTH;
  localparam int DEPTH     = IN_FLIGHT + 1;
  localparam int HOLD_MARK = DEPTH - IN_FLIGHT;
  localparam int META_W    = 4 + SID_W + TAG_W;
  localparam int CNT_W     = $clog2(DEPTH + 1);

  logic              is_free;
  logic              sel_flush;
  logic              sel_chunk;
  logic              occupied;
  logic              hold_now;
  logic              capture;
  logic              pop;
  logic              flush_now;
  logic              fifo_wr;
  logic              fifo_empty;
  logic              fifo_full;
  logic [CNT_W-1:0]  fifo_count;
  logic [META_W-1:0] fifo_rd_meta;
  logic [DATA_W-1:0] fifo_rd_data;
  logic [META_W-1:0] in_meta;
  logic              cap_q;
  logic [META_W-1:0] cap_meta_q;
  src_e              src_q;
  logic              stall_want;

  shb_classify #(.SID_W(SID_W)) u_classify (
    .kind      (in_kind),
    .last      (in_last),
    .flush     (in_flush),
    .strm      (in_strm),
    .sel       (hold_stream_i),
    .is_free   (is_free),
    .sel_flush (sel_flush),
    .sel_chunk (sel_chunk)
  );

  always_comb begin
    in_meta    = {in_kind, in_last, in_flush, in_strm, in_tag};
    flush_now  = sel_flush;
    occupied   = cap_q || (fifo_count >= CNT_W'(HOLD_MARK));
    // Any buffered entry forces later chunks behind it, preserving order.
    hold_now   = pause_i || cap_q || !fifo_empty;
    capture    = sel_chunk && hold_now;
    pop        = is_free && !pause_i && !fifo_empty;
    // The data word of a captured chunk lands one cycle after its control.
    fifo_wr    = cap_q && !flush_now;
    stall_want = pause_i || (occupied && !flush_now);
  end

  shb_fifo #(
    .DEPTH  (DEPTH),
    .META_W (META_W),
    .DATA_W (DATA_W)
  ) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .clear     (flush_now),
    .wr_en     (fifo_wr),
    .wr_meta   (cap_meta_q),
    .wr_data   (in_data),
    .rd_en     (pop),
    .rd_meta   (fifo_rd_meta),
    .rd_data_q (fifo_rd_data),
    .count     (fifo_count),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  shb_stall_gen #(.SID_W(SID_W)) u_stall (
    .clk     (clk),
    .rst     (rst),
    .want    (stall_want),
    .sel     (hold_stream_i),
    .stall_o (stall_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q      <= 1'b0;
      cap_meta_q <= '0;
    end else begin
      cap_q      <= capture;
      cap_meta_q <= in_meta;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {out_kind, out_last, out_flush, out_strm, out_tag} <= '0;
      src_q <= SRC_ZERO;
    end else if (pop) begin
      {out_kind, out_last, out_flush, out_strm, out_tag} <= fifo_rd_meta;
      src_q <= SRC_POP;
    end else if (capture) begin
      {out_kind, out_last, out_flush, out_strm, out_tag} <= '0;
      src_q <= SRC_ZERO;
    end else begin
      {out_kind, out_last, out_flush, out_strm, out_tag} <= in_meta;
      src_q <= SRC_PASS;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data <= '0;
    end else begin
      case (src_q)
        SRC_POP:  out_data <= fifo_rd_data;
        SRC_PASS: out_data <= in_data;
        default:  out_data <= '0;
      endcase
    end
  end

endmodule

// File: rtl/shb_checker.sv
module shb_checker
  import shb_pkg::*;
#(
  parameter int SID_W = 3,
  parameter int DEPTH = 6,
  parameter int CNT_W = 3,
  localparam int NUM_STREAMS = 1 << SID_W
) (
  input logic                   clk,
  input logic                   rst,
  input logic [1:0]             in_kind,
  input logic [SID_W-1:0]       in_strm,
  input logic [1:0]             out_kind,
  input logic                   out_last,
  input logic                   out_flush,
  input logic [SID_W-1:0]       out_strm,
  input logic [NUM_STREAMS-1:0] stall_o,
  input logic                   capture,
  input logic                   pop,
  input logic                   is_free,
  input logic                   flush_now,
  input logic                   fifo_wr,
  input logic [CNT_W-1:0]       fifo_count,
  input logic                   fifo_empty
);

  // R1: never more than one stall bit
  p_stall_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stall_o));

  // R3: a captured slot leaves as a free chunk
  p_free_on_capture_r3: assert property (@(posedge clk) disable iff (rst)
    capture |=> (out_kind == K_IDLE) && !out_last && !out_flush);

  // R4: setup and memory chunks are never held
  p_side_pass_r4: assert property (@(posedge clk) disable iff (rst)
    ((in_kind == K_SETUP) || (in_kind == K_MEM)) |=>
      (out_kind == $past(in_kind)) && (out_strm == $past(in_strm)));

  // R5, R11: release only into a free slot and only from a non-empty buffer
  p_pop_free_r5: assert property (@(posedge clk) disable iff (rst)
    pop |-> is_free && !fifo_empty);

  // R7: a flush leaves the buffer empty
  p_flush_clears_r7: assert property (@(posedge clk) disable iff (rst)
    flush_now |=> fifo_empty);

  // R8: no chunk of the held stream may land in a full buffer
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> (fifo_count < CNT_W'(DEPTH)));

endmodule

bind stream_hold_buffer shb_checker #(
  .SID_W (SID_W),
  .DEPTH (DEPTH),
  .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_kind    (in_kind),
  .in_strm    (in_strm),
  .out_kind   (out_kind),
  .out_last   (out_last),
  .out_flush  (out_flush),
  .out_strm   (out_strm),
  .stall_o    (stall_o),
  .capture    (capture),
  .pop        (pop),
  .is_free    (is_free),
  .flush_now  (flush_now),
  .fifo_wr    (fifo_wr),
  .fifo_count (fifo_count),
  .fifo_empty (fifo_empty)
);

// File: tb/stream_hold_buffer_bench.sv
module stream_hold_buffer_bench;

  localparam int SID_W  = 3;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 32;
  localparam int NS     = 1 << SID_W;
  localparam int CAP    = 2 + 3 + 1;
  localparam int PACK_W = 4 + SID_W + TAG_W + DATA_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [SID_W-1:0]  hold_stream_i = 3'd3;
  logic              pause_i = 1'b0;
  logic [1:0]        in_kind = 2'b00;
  logic              in_last = 1'b0;
  logic              in_flush = 1'b0;
  logic [SID_W-1:0]  in_strm = '0;
  logic [TAG_W-1:0]  in_tag = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic [1:0]        out_kind;
  logic              out_last;
  logic              out_flush;
  logic [SID_W-1:0]  out_strm;
  logic [TAG_W-1:0]  out_tag;
  logic [DATA_W-1:0] out_data;
  logic [NS-1:0]     stall_o;

  int checks = 0;
  int fails  = 0;
  logic              cur_pause = 1'b0;
  logic [DATA_W-1:0] nxt_data = '0;

  logic [PACK_W-1:0] lg [64];
  int                n_log = 0;
  logic              prev_v = 1'b0;
  logic [PACK_W-DATA_W-1:0] prev_ctl = '0;

  always #4 clk = ~clk;

  stream_hold_buffer #(
    .SID_W(SID_W), .TAG_W(TAG_W), .DATA_W(DATA_W),
    .STALL_DELAY(2), .UP_DEPTH(3)
  ) u_stream_hold_buffer (
    .clk(clk), .rst(rst), .hold_stream_i(hold_stream_i), .pause_i(pause_i),
    .in_kind(in_kind), .in_last(in_last), .in_flush(in_flush),
    .in_strm(in_strm), .in_tag(in_tag), .in_data(in_data),
    .out_kind(out_kind), .out_last(out_last), .out_flush(out_flush),
    .out_strm(out_strm), .out_tag(out_tag), .out_data(out_data),
    .stall_o(stall_o)
  );

  // Recorder: every non-free output chunk, joined with the data of the next cycle.
  always @(posedge clk) begin
    #1;
    if (prev_v && n_log < 64) begin
      lg[n_log] = {prev_ctl, out_data};
      n_log++;
    end
    prev_v   = !rst && !((out_kind == 2'b00) && !out_last && !out_flush);
    prev_ctl = {out_kind, out_last, out_flush, out_strm, out_tag};
  end

  task automatic chk(input string req, input string what,
                     input logic [PACK_W-1:0] act, input logic [PACK_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] k, input logic l, input logic f,
                       input int s, input int t, input logic [DATA_W-1:0] d);
    @(negedge clk);
    pause_i  = cur_pause;
    in_kind  = k;
    in_last  = l;
    in_flush = f;
    in_strm  = SID_W'(s);
    in_tag   = TAG_W'(t);
    in_data  = nxt_data;
    nxt_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(2'b00, 1'b0, 1'b0, 0, 0, '0);
  endtask

  task automatic expect_log(input int idx, input string req,
                            input logic [1:0] k, input logic l, input logic f,
                            input int s, input int t, input logic [DATA_W-1:0] d);
    chk(req, $sformatf("log[%0d]", idx), lg[idx],
        {k, l, f, SID_W'(s), TAG_W'(t), d});
  endtask

  task automatic sample_after_edge();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #2;
    chk("R9", "out_kind in reset", PACK_W'(out_kind), PACK_W'(2'b00));
    chk("R9", "stall in reset", PACK_W'(stall_o), '0);
    chk("R9", "out_data in reset", PACK_W'(out_data), '0);
    @(negedge clk);
    rst = 1'b0;
    idle(2);
  endtask

  task automatic t_pass();
    cur_pause = 1'b0;
    n_log = 0;
    drive(2'b01, 1'b0, 1'b0, 1, 1, 32'hA1);
    sample_after_edge();
    chk("R10", "control one cycle later", PACK_W'({out_kind, out_strm}),
        PACK_W'({2'b01, 3'd1}));
    drive(2'b01, 1'b0, 1'b0, 2, 2, 32'hA2);
    drive(2'b11, 1'b0, 1'b0, 0, 5, 32'hA3);
    drive(2'b01, 1'b0, 1'b0, 3, 4, 32'hA4);
    idle(4);
    chk("R4", "pass count", PACK_W'(n_log), PACK_W'(4));
    expect_log(0, "R4", 2'b01, 0, 0, 1, 1, 32'hA1);
    expect_log(1, "R10", 2'b01, 0, 0, 2, 2, 32'hA2);
    expect_log(2, "R4", 2'b11, 0, 0, 0, 5, 32'hA3);
    expect_log(3, "R4", 2'b01, 0, 0, 3, 4, 32'hA4);
  endtask

  task automatic t_hold_release();
    n_log = 0;
    cur_pause = 1'b1;
    drive(2'b01, 1'b0, 1'b0, 3, 1, 32'hB1);
    sample_after_edge();
    chk("R3", "captured slot is free", PACK_W'({out_kind, out_last, out_flush}), '0);
    drive(2'b01, 1'b0, 1'b0, 5, 2, 32'hB2);
    drive(2'b01, 1'b0, 1'b0, 3, 3, 32'hB3);
    drive(2'b10, 1'b0, 1'b0, 3, 9, 32'hB4);
    idle(2);
    sample_after_edge();
    chk("R1", "only held bit", PACK_W'(stall_o), PACK_W'(8'h08));
    chk("R4", "held-time pass count", PACK_W'(n_log), PACK_W'(2));
    expect_log(0, "R4", 2'b01, 0, 0, 5, 2, 32'hB2);
    expect_log(1, "R4", 2'b10, 0, 0, 3, 9, 32'hB4);
    cur_pause = 1'b0;
    idle(1);
    sample_after_edge();
    chk("R2", "stall while still occupied", PACK_W'(stall_o), PACK_W'(8'h08));
    idle(6);
    chk("R5", "release count", PACK_W'(n_log), PACK_W'(4));
    expect_log(2, "R5", 2'b01, 0, 0, 3, 1, 32'hB1);
    expect_log(3, "R5", 2'b01, 0, 0, 3, 3, 32'hB3);
    chk("R2", "stall after drain", PACK_W'(stall_o), '0);
  endtask

  task automatic t_order();
    n_log = 0;
    cur_pause = 1'b1;
    drive(2'b01, 1'b0, 1'b0, 3, 1, 32'hC1);
    drive(2'b01, 1'b0, 1'b0, 3, 2, 32'hC2);
    cur_pause = 1'b0;
    drive(2'b01, 1'b0, 1'b0, 3, 3, 32'hC3);
    drive(2'b00, 1'b1, 1'b0, 2, 7, 32'h0);
    idle(7);
    chk("R6", "order count", PACK_W'(n_log), PACK_W'(4));
    expect_log(0, "R11", 2'b00, 1, 0, 2, 7, 32'h0);
    expect_log(1, "R6", 2'b01, 0, 0, 3, 1, 32'hC1);
    expect_log(2, "R6", 2'b01, 0, 0, 3, 2, 32'hC2);
    expect_log(3, "R6", 2'b01, 0, 0, 3, 3, 32'hC3);
  endtask

  task automatic t_flush();
    n_log = 0;
    cur_pause = 1'b1;
    drive(2'b01, 1'b0, 1'b0, 3, 1, 32'hD1);
    drive(2'b01, 1'b0, 1'b0, 3, 2, 32'hD2);
    cur_pause = 1'b0;
    drive(2'b00, 1'b0, 1'b1, 3, 0, 32'h0);
    sample_after_edge();
    chk("R7", "stall drops after flush", PACK_W'(stall_o), '0);
    idle(6);
    chk("R7", "only flush leaves", PACK_W'(n_log), PACK_W'(1));
    expect_log(0, "R7", 2'b00, 0, 1, 3, 0, 32'h0);
  endtask

  task automatic t_capacity();
    n_log = 0;
    cur_pause = 1'b1;
    for (int i = 0; i < CAP; i++) drive(2'b01, 1'b0, 1'b0, 3, i, DATA_W'(32'h100 + i));
    idle(2);
    chk("R8", "nothing leaves while full", PACK_W'(n_log), '0);
    cur_pause = 1'b0;
    idle(CAP + 4);
    chk("R8", "full release count", PACK_W'(n_log), PACK_W'(CAP));
    for (int i = 0; i < CAP; i++)
      expect_log(i, "R8", 2'b01, 0, 0, 3, i, DATA_W'(32'h100 + i));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_pass();
    t_hold_release();
    t_order();
    t_flush();
    t_capacity();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule